// File: doc/BRIEF.md
# Mailbox interrupt register bank

This block is a small register file shared by two bus masters: a host on one side and a local bus on the other. It carries two sets of eight 32-bit mailboxes. The local side fills the local-to-host set, which the host may only read. The host fills the host-to-local set, which the local side may only read. Every local write into a local-to-host mailbox raises a sticky flag that the host clears by writing a one to it.

The host sees one status word. The flags sit in bits 23:16. Bits 15:0 give a live, non-sticky view of up to sixteen local interrupt lines. A matching enable word masks each group, and the bank drives one registered interrupt request toward the host. The request is high while any enabled status bit is set. Both buses use a single-cycle write strobe and a combinational read of the addressed word.

Top module: `mbox_irq_bank`

## Requirements
- R1: After an active-low synchronous reset, every mailbox, every flag and every enable bit is 0, and `irq_out` is 0.
- R2: A host read of byte address 0x40 returns the current `irq_in` level in bits [NUM_IRQ-1:0], with 1 meaning the line is asserted. Host writes cannot change these bits.
- R3: A local write to byte address 0x80+4n (n in 0..7) stores the data in local-to-host mailbox n. Status bit 16+n reads 1 from the next cycle on.
- R4: A host write to 0x40 clears each status bit in 23:16 whose write-data bit is 1. Bits written 0 keep their value.
- R5: If a local write to mailbox n lands in the same cycle as a host clear of bit 16+n, the bit ends at 1.
- R6: Byte address 0x50 holds the enable word. Bits 23:16 enable the mailbox flags and bits 15:0 enable the IRQ lines. Bits 31:24 of both the status word and the enable word read 0, and writes to them are ignored.
- R7: The host reads local-to-host mailbox n at 0x80+4n. Host writes to those addresses leave the mailbox unchanged.
- R8: The host writes host-to-local mailbox n at 0xA0+4n. Both sides read it back at that address. Local writes to those addresses are ignored.
- R9: `irq_out` is registered. It is 1 in the cycle after one in which some status bit and its enable bit are both 1. It is 0 in the cycle after none are.
- R10: Reads of any other address, including addresses that are not word aligned, return 0 on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 8 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for `h_addr` (combinational) |
| l_wr | input | 1 | Local write strobe |
| l_addr | input | 8 | Local byte address |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data for `l_addr` (combinational) |
| irq_in | input | NUM_IRQ | Local interrupt levels, synchronous to `clk` |
| irq_out | output | 1 | Interrupt request toward the host |

## Verification
A flag that is wrongly set or wrongly cleared shows up two ways. It appears in the status word on the next host read. It also moves `irq_out` one cycle after the flag changes, but only if that flag is enabled. A corrupted mailbox or enable bit stays hidden until the word is read or until an enable gates a pending flag. For that reason the bench steps the address through every register and compares reads and `irq_out` against a reference model on every cycle. A set-versus-clear race that resolves the wrong way loses the flag for good, and the next status read exposes it.

// File: rtl/mbox_bank_pkg.sv
// Shared constants and address decode helper for the mailbox interrupt bank.
// Assumes byte addressing with 32-bit words, so bits [1:0] of a valid word address are zero.
package mbox_bank_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int FLAG_LSB  = 16;
    localparam int MAX_MB    = 8;
    localparam int MAX_IRQ   = 16;

    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_ENABLE   = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_L2H_BASE = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_H2L_BASE = 8'hA0;

    typedef struct packed {
        logic       hit;
        logic [2:0] idx;
    } mb_sel_t;

    // Decode one aligned word inside a mailbox window of 'count' words.
    function automatic mb_sel_t decode_mb(input logic [ADDR_W-1:0] addr,
                                          input logic [ADDR_W-1:0] base,
                                          input int unsigned count);
        mb_sel_t           sel;
        logic [ADDR_W-1:0] off;
        off     = addr - base;
        sel.hit = (addr >= base) && (off[1:0] == 2'b00) &&
                  (32'(off[ADDR_W-1:2]) < count);
        sel.idx = off[4:2];
        return sel;
    endfunction
endpackage

// File: rtl/mbox_regfile.sv
// Bank of N word registers with a single write port and all entries visible in parallel.
// Assumes wr_idx < N whenever wr_en is high; the caller decodes the address.
module mbox_regfile #(
    parameter int N = 8,
    parameter int W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [W-1:0]        wr_data,
    output logic [N-1:0][W-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_word
        // Load entry i on a write addressed to it; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
                q[i] <= wr_data;
        end
    end
endmodule

// File: rtl/mbox_flag_bank.sv
// Sticky event flags: a set pulse raises a flag, a clear vector drops it.
// Assumes set and clear are single-cycle vectors; when both hit the same bit, set wins.
module mbox_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);
    // Apply clears first, then sets, so a coincident set survives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/mbox_irq_gen.sv
// Masks a pending vector with an enable vector and registers the OR as the interrupt.
// Assumes both vectors are synchronous to clk; output lags the inputs by one cycle.
module mbox_irq_gen #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pending,
    input  logic [W-1:0] enable,
    output logic         irq
);
    logic req_now;

    // Combine every enabled pending source into one request.
    always_comb req_now = |(pending & enable);

    // Register the request so the output is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= req_now;
    end
endmodule

// File: rtl/mbox_irq_bank.sv
// Mailbox interrupt register bank: two mailbox sets, sticky write flags, live IRQ view,
// enable masks and one registered interrupt toward the host.
// Assumes both buses and irq_in are synchronous to clk; reads are combinational.
module mbox_irq_bank
    import mbox_bank_pkg::*;
#(
    parameter int NUM_MB  = 8,
    parameter int NUM_IRQ = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                h_wr,
    input  logic [7:0]          h_addr,
    input  logic [31:0]         h_wdata,
    output logic [31:0]         h_rdata,
    input  logic                l_wr,
    input  logic [7:0]          l_addr,
    input  logic [31:0]         l_wdata,
    output logic [31:0]         l_rdata,
    input  logic [NUM_IRQ-1:0]  irq_in,
    output logic                irq_out
);
    localparam int MB_IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;
    localparam int SRC_W    = NUM_MB + NUM_IRQ;

    mb_sel_t h_l2h, h_h2l, l_l2h, l_h2l;
    logic [NUM_MB-1:0][WORD_W-1:0] l2h_q, h2l_q;
    logic [NUM_MB*WORD_W-1:0]      l2h_flat;
    logic [NUM_MB-1:0]             flags_q, set_vec, clr_vec, en_mb_q;
    logic [NUM_IRQ-1:0]            en_irq_q;
    logic [WORD_W-1:0]             status_w, enable_w;
    logic                          h_sel_status, h_sel_enable;
    logic                          unused_ok;

    // Decode both bus addresses into the two mailbox windows.
    always_comb begin
        h_l2h = decode_mb(h_addr, OFS_L2H_BASE, NUM_MB);
        h_h2l = decode_mb(h_addr, OFS_H2L_BASE, NUM_MB);
        l_l2h = decode_mb(l_addr, OFS_L2H_BASE, NUM_MB);
        l_h2l = decode_mb(l_addr, OFS_H2L_BASE, NUM_MB);
        h_sel_status = (h_addr == OFS_STATUS);
        h_sel_enable = (h_addr == OFS_ENABLE);
    end

    // Local-to-host mailboxes: only the local side writes them.
    mbox_regfile #(.N(NUM_MB), .W(WORD_W)) u_l2h (
        .clk(clk), .rst_n(rst_n),
        .wr_en(l_wr && l_l2h.hit),
        .wr_idx(l_l2h.idx[MB_IDX_W-1:0]),
        .wr_data(l_wdata),
        .q(l2h_q)
    );

    // Host-to-local mailboxes: only the host writes them.
    mbox_regfile #(.N(NUM_MB), .W(WORD_W)) u_h2l (
        .clk(clk), .rst_n(rst_n),
        .wr_en(h_wr && h_h2l.hit),
        .wr_idx(h_h2l.idx[MB_IDX_W-1:0]),
        .wr_data(h_wdata),
        .q(h2l_q)
    );

    // Flag set on each local mailbox write, clear on host write-one to the status word.
    always_comb begin
        set_vec = '0;
        if (l_wr && l_l2h.hit)
            set_vec[l_l2h.idx[MB_IDX_W-1:0]] = 1'b1;
        clr_vec = (h_wr && h_sel_status) ? h_wdata[FLAG_LSB +: NUM_MB] : '0;
    end

    mbox_flag_bank #(.N(NUM_MB)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .clr_vec(clr_vec),
        .flags(flags_q)
    );

    // Enable word: implemented fields only; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_mb_q  <= '0;
            en_irq_q <= '0;
        end else if (h_wr && h_sel_enable) begin
            en_mb_q  <= h_wdata[FLAG_LSB +: NUM_MB];
            en_irq_q <= h_wdata[NUM_IRQ-1:0];
        end
    end

    // Combined interrupt request over flags and live lines.
    mbox_irq_gen #(.W(SRC_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .pending({flags_q, irq_in}),
        .enable({en_mb_q, en_irq_q}),
        .irq(irq_out)
    );

    // Assemble the status and enable words with unused bits held at zero.
    always_comb begin
        status_w = '0;
        status_w[NUM_IRQ-1:0]          = irq_in;
        status_w[FLAG_LSB +: NUM_MB]   = flags_q;
        enable_w = '0;
        enable_w[NUM_IRQ-1:0]          = en_irq_q;
        enable_w[FLAG_LSB +: NUM_MB]   = en_mb_q;
    end

    // Host read multiplexer.
    always_comb begin
        h_rdata = '0;
        if (h_sel_status)
            h_rdata = status_w;
        else if (h_sel_enable)
            h_rdata = enable_w;
        else if (h_l2h.hit)
            h_rdata = l2h_q[h_l2h.idx[MB_IDX_W-1:0]];
        else if (h_h2l.hit)
            h_rdata = h2l_q[h_h2l.idx[MB_IDX_W-1:0]];
    end

    // Local read multiplexer: mailboxes only.
    always_comb begin
        l_rdata = '0;
        if (l_l2h.hit)
            l_rdata = l2h_q[l_l2h.idx[MB_IDX_W-1:0]];
        else if (l_h2l.hit)
            l_rdata = h2l_q[l_h2l.idx[MB_IDX_W-1:0]];
    end

    // Flattened view of the local-to-host set for the bound checker.
    always_comb l2h_flat = l2h_q;

    always_comb unused_ok = &{1'b0, h_wdata, h_l2h.idx, l_h2l.idx};
endmodule

// File: rtl/mbox_irq_bank_chk.sv
// Property checker for the mailbox interrupt bank, attached through bind.
// Assumes the fixed address map of mbox_bank_pkg.
module mbox_irq_bank_chk #(
    parameter int NUM_MB  = 8,
    parameter int NUM_IRQ = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     h_wr,
    input logic [7:0]               h_addr,
    input logic [31:0]              h_wdata,
    input logic [31:0]              h_rdata,
    input logic                     l_wr,
    input logic [7:0]               l_addr,
    input logic [NUM_IRQ-1:0]       irq_in,
    input logic                     irq_out,
    input logic [NUM_MB-1:0]        flags,
    input logic [NUM_MB-1:0]        en_mb,
    input logic [NUM_IRQ-1:0]       en_irq,
    input logic [NUM_MB*32-1:0]     l2h_flat
);
    logic l_mb_wr;
    always_comb l_mb_wr = l_wr && (l_addr[7:5] == 3'b100) && (l_addr[1:0] == 2'b00) &&
                          (32'(l_addr[4:2]) < NUM_MB);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> !irq_out);

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|({flags, irq_in} & {en_mb, en_irq})));

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_mb_wr |=> flags[$past(l_addr[4:2])]);

    // R7
    l2h_host_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && !l_wr) |=> $stable(l2h_flat));

    // R6
    enable_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_addr == 8'h50 || h_addr == 8'h40) |-> (h_rdata[31:24] == 8'h00));

    for (genvar n = 0; n < NUM_MB; n++) begin : g_clr
        // R4
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (h_wr && h_addr == 8'h40 && h_wdata[16+n] &&
             !(l_mb_wr && l_addr[4:2] == 3'(n))) |=> !flags[n]);
    end
endmodule

bind mbox_irq_bank mbox_irq_bank_chk #(.NUM_MB(NUM_MB), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .l_wr(l_wr), .l_addr(l_addr),
    .irq_in(irq_in), .irq_out(irq_out),
    .flags(flags_q), .en_mb(en_mb_q), .en_irq(en_irq_q),
    .l2h_flat(l2h_flat)
);

// File: tb/tb_mbox_irq_bank.sv
module tb_mbox_irq_bank;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        h_wr = 0, l_wr = 0;
    logic [7:0]  h_addr = 0, l_addr = 0;
    logic [31:0] h_wdata = 0, l_wdata = 0;
    logic [31:0] h_rdata, l_rdata;
    logic [15:0] irq_in = 0;
    logic        irq_out;

    int total = 0, bad = 0;
    bit started = 0, done = 0;
    string cur_req = "R1";

    // Reference model state
    logic [31:0] m_l2h [8];
    logic [31:0] m_h2l [8];
    logic [7:0]  m_flags;
    logic [23:0] m_en;
    logic        m_irq;

    mbox_irq_bank dut (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    function automatic int win(input logic [7:0] a, input logic [7:0] base);
        if (a >= base && a < base + 8'd32 && a[1:0] == 2'b00) return int'((a - base) >> 2);
        return -1;
    endfunction

    function automatic logic [31:0] exp_host(input logic [7:0] a);
        if (a == 8'h40) return {8'h00, m_flags, irq_in};
        if (a == 8'h50) return {8'h00, m_en};
        if (win(a, 8'h80) >= 0) return m_l2h[win(a, 8'h80)];
        if (win(a, 8'hA0) >= 0) return m_h2l[win(a, 8'hA0)];
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_local(input logic [7:0] a);
        if (win(a, 8'h80) >= 0) return m_l2h[win(a, 8'h80)];
        if (win(a, 8'hA0) >= 0) return m_h2l[win(a, 8'hA0)];
        return 32'h0;
    endfunction

    // Model update on each rising edge, from the inputs held since the previous step
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_l2h[i] = 0; m_h2l[i] = 0; end
            m_flags = 0; m_en = 0; m_irq = 0;
        end else begin
            m_irq = |(m_flags & m_en[23:16]) | |(irq_in & m_en[15:0]);
            if (h_wr) begin
                if (h_addr == 8'h50) m_en = h_wdata[23:0];
                if (h_addr == 8'h40) m_flags = m_flags & ~h_wdata[23:16];
                if (win(h_addr, 8'hA0) >= 0) m_h2l[win(h_addr, 8'hA0)] = h_wdata;
            end
            if (l_wr && win(l_addr, 8'h80) >= 0) begin
                m_l2h[win(l_addr, 8'h80)] = l_wdata;
                m_flags[win(l_addr, 8'h80)] = 1'b1;
            end
        end
        started = 1;
    end

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Compare every output against the model away from the rising edge
    always @(negedge clk) begin
        if (started && !done) begin
            cmp("irq_out", {31'b0, irq_out}, {31'b0, m_irq});
            cmp("h_rdata", h_rdata, exp_host(h_addr));
            cmp("l_rdata", l_rdata, exp_local(l_addr));
        end
    end

    task automatic step(input logic hw, input logic [7:0] ha, input logic [31:0] hd,
                        input logic lw, input logic [7:0] la, input logic [31:0] ld);
        @(posedge clk); #3;
        h_wr = hw; h_addr = ha; h_wdata = hd;
        l_wr = lw; l_addr = la; l_wdata = ld;
    endtask

    task automatic hread(input logic [7:0] a); step(0, a, 0, 0, 8'h00, 0); endtask

    initial begin
        // R1: reset state of all registers and irq_out
        cur_req = "R1";
        repeat (3) step(0, 8'h40, 0, 0, 8'h80, 0);
        @(posedge clk); #3 rst_n = 1;
        hread(8'h40); hread(8'h50); hread(8'h84); hread(8'hA4);

        // R2: live IRQ level view, host writes cannot alter it
        cur_req = "R2";
        irq_in = 16'hA5C3; hread(8'h40);
        irq_in = 16'h0001; hread(8'h40);
        step(1, 8'h40, 32'h0000FFFF, 0, 0, 0);
        irq_in = 16'h0000; hread(8'h40);

        // R3: each local mailbox write sets its flag
        cur_req = "R3";
        for (int n = 0; n < 8; n++) step(0, 8'h40, 0, 1, 8'(8'h80 + 4*n), 32'h1000 + n);
        hread(8'h40);

        // R7: host reads local-to-host mailboxes, host writes ignored
        cur_req = "R7";
        step(1, 8'h84, 32'hDEADBEEF, 0, 0, 0);
        hread(8'h84); hread(8'h9C);

        // R4: write-one clears, write-zero keeps
        cur_req = "R4";
        step(1, 8'h40, 32'h00050000, 0, 0, 0);
        hread(8'h40);
        step(1, 8'h40, 32'h00000000, 0, 0, 0);
        hread(8'h40);

        // R5: coincident set and clear of flag 3, set wins
        cur_req = "R5";
        step(1, 8'h40, 32'h00FF0000, 1, 8'h8C, 32'h33);
        hread(8'h40);

        // R6: enable word fields and reserved bits
        cur_req = "R6";
        step(1, 8'h50, 32'hFFFFFFFF, 0, 0, 0);
        hread(8'h50);
        step(1, 8'h40, 32'hFF000000, 0, 0, 0);
        hread(8'h40);
        step(1, 8'h50, 32'h0, 0, 0, 0);
        hread(8'h50);

        // R8: host-to-local mailboxes, local writes ignored
        cur_req = "R8";
        step(1, 8'hA8, 32'hCAFE0002, 0, 0, 0);
        step(0, 8'hA8, 0, 1, 8'hA8, 32'h12345678);
        step(0, 8'hA8, 0, 0, 8'hA8, 0);
        step(0, 8'hBC, 0, 0, 8'hBC, 0);

        // R9: interrupt timing with flags, masks and live lines
        cur_req = "R9";
        step(1, 8'h40, 32'h00FF0000, 0, 0, 0);
        step(1, 8'h50, 32'h00010000, 0, 0, 0);
        step(0, 8'h40, 0, 1, 8'h80, 32'h1);
        hread(8'h40); hread(8'h40);
        step(1, 8'h40, 32'h00010000, 0, 0, 0);
        hread(8'h40); hread(8'h40);
        step(1, 8'h50, 32'h00000004, 0, 0, 0);
        irq_in = 16'h0004; hread(8'h40); hread(8'h40);
        irq_in = 16'h0000; hread(8'h40); hread(8'h40);

        // R10: unmapped and unaligned addresses read zero
        cur_req = "R10";
        step(0, 8'h10, 0, 0, 8'h40, 0);
        step(0, 8'h82, 0, 0, 8'h83, 0);
        step(0, 8'hFC, 0, 0, 8'hC0, 0);

        // R9: mixed traffic compared on every clock
        cur_req = "R9";
        for (int i = 0; i < 400; i++) begin
            irq_in = 16'($urandom);
            step(1'($urandom), 8'($urandom_range(16, 63) * 4), $urandom,
                 1'($urandom), 8'($urandom_range(16, 63) * 4), $urandom);
        end
        hread(8'h40);
        @(posedge clk); #3;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule